// File: doc/BRIEF.md
# Ratio-Aligned Dual Clock Enable Generator

This block runs entirely on one source clock and derives two clock-enable streams from it by integer division: one paces a network domain, the other a memory domain. Each domain also counts its own ticks inside a service cycle, a fixed number of domain ticks after which one fixed-size transfer is complete. The generator raises a one-cycle boundary strobe on the source edge where both domains complete a service cycle together. Downstream schedulers can then hand one transfer per service cycle from the network side straight to the memory side, with no arbitration or buffering between them.

A configuration is four numbers: the network divide ratio, the memory divide ratio, and the service-cycle length of each domain counted in that domain's own ticks. The configuration is captured on a load pulse and checked at the same time. If the two service cycles do not last the same number of source cycles, the two domains can never share a boundary. An error flag is then raised and the block stays silent until a valid configuration is loaded. Loading restarts both dividers and both counters from a common phase.

Top module: `ratio_clk_enable_gen`

## Requirements
- R1: In the first cycle after synchronous active-low reset, both enables and the strobe are low, both service counters read 0, and the error flag is high, since no configuration is held.
- R2: A configuration captured on a load edge is valid exactly when all four values are nonzero and network ratio × network length equals memory ratio × memory length. The error flag is the inverse of that verdict from the first cycle after the load edge.
- R3: With a valid configuration and i counting source cycles from 0 in the first cycle after the load edge, the network enable is high exactly in the cycles where i mod m = m−1 (m is the network ratio).
- R4: Under the same counting, the memory enable is high exactly in the cycles where i mod n = n−1 (n is the memory ratio).
- R5: The network counter reads floor(i/m) mod network length, and the memory counter reads floor(i/n) mod memory length.
- R6: The boundary strobe is high for exactly one cycle, in the cycles where (i+1) mod (m × network length) = 0. In those cycles both domains complete their service cycle together.
- R7: While the error flag is high, both enables and the strobe stay low and both counters hold 0.
- R8: Config inputs have no effect unless the load input is high at a clock edge. Every load edge restarts both dividers and both counters from 0, whatever their earlier phase.
- R9: A divide ratio of 1 gives an enable that is high in every cycle of a valid configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Capture and check the config inputs at this edge |
| net_div_in | input | DIV_W (8) | Network divide ratio m |
| mem_div_in | input | DIV_W (8) | Memory divide ratio n |
| net_len_in | input | LEN_W (8) | Network service-cycle length in network ticks |
| mem_len_in | input | LEN_W (8) | Memory service-cycle length in memory ticks |
| net_en | output | 1 | Network domain clock enable |
| mem_en | output | 1 | Memory domain clock enable |
| net_cnt | output | LEN_W (8) | Network tick position inside its service cycle |
| mem_cnt | output | LEN_W (8) | Memory tick position inside its service cycle |
| sc_boundary | output | 1 | Common service-cycle boundary strobe |
| cfg_err | output | 1 | Loaded configuration cannot align |

## Verification
All outputs are combinational functions of registers that update on the load edge. The verdict, enables, counters and strobe for index i=0 are therefore due in the very first cycle after that edge, and each later index one source cycle later. The driver computes the whole expected sequence from the requirement formulas before the load edge and queues it. The monitor pops one item per cycle, sampling on the falling edge, so item k always meets cycle i=k. Immediately after each load edge the driver scrambles the config inputs, so any leak of unloaded inputs shows up in the queued comparisons.

// File: rtl/cdg_pkg.sv
// Shared widths, the configuration record and the alignment check.
// Assumes: ratios and lengths are unsigned; the products fit in PROD_W bits.
package cdg_pkg;
    parameter int DIV_W  = 8;
    parameter int LEN_W  = 8;
    localparam int PROD_W = DIV_W + LEN_W;

    typedef struct packed {
        logic [DIV_W-1:0] net_div;
        logic [DIV_W-1:0] mem_div;
        logic [LEN_W-1:0] net_len;
        logic [LEN_W-1:0] mem_len;
    } cdg_cfg_t;

    // Both service cycles must span the same number of source cycles.
    function automatic logic cfg_aligned(cdg_cfg_t c);
        logic [PROD_W-1:0] net_span;
        logic [PROD_W-1:0] mem_span;
        logic              nonzero;
        net_span = PROD_W'(c.net_div) * PROD_W'(c.net_len);
        mem_span = PROD_W'(c.mem_div) * PROD_W'(c.mem_len);
        nonzero  = (c.net_div != '0) && (c.mem_div != '0) &&
                   (c.net_len != '0) && (c.mem_len != '0);
        return nonzero && (net_span == mem_span);
    endfunction
endpackage

// File: rtl/cdg_cfg_reg.sv
// Configuration holding register with registered validity verdict.
// Assumes: load is a synchronous request; reset leaves an empty (invalid) config.
module cdg_cfg_reg
    import cdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  cdg_cfg_t cfg_in,
    output cdg_cfg_t cfg_q,
    output logic     ok_q
);
    // Capture the configuration and its verdict on a load edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ok_q  <= 1'b0;
        end else if (load) begin
            cfg_q <= cfg_in;
            ok_q  <= cfg_aligned(cfg_in);
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_q) && $stable(ok_q)); // R8
endmodule

// File: rtl/cdg_domain_div.sv
// One divided domain: prescaler producing the enable, plus a service-cycle
// tick counter. Assumes div and len are nonzero whenever run is high.
module cdg_domain_div
    import cdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic [LEN_W-1:0] len,
    output logic             tick,
    output logic             last,
    output logic [LEN_W-1:0] cnt
);
    localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);
    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    logic [DIV_W-1:0] pre;

    // Enable fires on the final prescaler count; last marks the final tick of a service cycle.
    always_comb begin
        tick = run && (pre == div - ONE_D);
        last = tick && (cnt == len - ONE_L);
    end

    // Advance prescaler and service counter; clear on reset or reload.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre <= '0;
            cnt <= '0;
        end else if (run) begin
            pre <= tick ? '0 : pre + ONE_D;
            if (tick) begin
                cnt <= last ? '0 : cnt + ONE_L;
            end
        end
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre < div)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && !last) |=> (cnt == $past(cnt) + ONE_L)); // R5
endmodule

// File: rtl/cdg_boundary.sv
// Common service-cycle boundary detector.
// Assumes: both domain counters were cleared on the same edge.
module cdg_boundary (
    input  logic clk,
    input  logic rst_n,
    input  logic ok,
    input  logic net_last,
    input  logic mem_last,
    output logic strobe
);
    // Strobe only when both domains finish a service cycle on this edge.
    always_comb strobe = ok && net_last && mem_last;

    AST_NET_WRAP_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && net_last) |-> mem_last); // R6
    AST_MEM_WRAP_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && mem_last) |-> net_last); // R6
endmodule

// File: rtl/ratio_clk_enable_gen.sv
// Top: two integer-divided enable streams from one source clock, phase
// aligned on a common service-cycle boundary. Assumes one clock, sync reset.
module ratio_clk_enable_gen
    import cdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [DIV_W-1:0] net_div_in,
    input  logic [DIV_W-1:0] mem_div_in,
    input  logic [LEN_W-1:0] net_len_in,
    input  logic [LEN_W-1:0] mem_len_in,
    output logic             net_en,
    output logic             mem_en,
    output logic [LEN_W-1:0] net_cnt,
    output logic [LEN_W-1:0] mem_cnt,
    output logic             sc_boundary,
    output logic             cfg_err
);
    cdg_cfg_t cfg_in, cfg_q;
    logic     ok_q;
    logic     net_last, mem_last;

    // Gather the config inputs into one record.
    always_comb begin
        cfg_in.net_div = net_div_in;
        cfg_in.mem_div = mem_div_in;
        cfg_in.net_len = net_len_in;
        cfg_in.mem_len = mem_len_in;
    end

    cdg_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .ok_q   (ok_q)
    );

    cdg_domain_div u_net (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_load),
        .run   (ok_q),
        .div   (cfg_q.net_div),
        .len   (cfg_q.net_len),
        .tick  (net_en),
        .last  (net_last),
        .cnt   (net_cnt)
    );

    cdg_domain_div u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_load),
        .run   (ok_q),
        .div   (cfg_q.mem_div),
        .len   (cfg_q.mem_len),
        .tick  (mem_en),
        .last  (mem_last),
        .cnt   (mem_cnt)
    );

    cdg_boundary u_bnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ok       (ok_q),
        .net_last (net_last),
        .mem_last (mem_last),
        .strobe   (sc_boundary)
    );

    // Error flag is the inverse of the held verdict.
    always_comb cfg_err = !ok_q;

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!net_en && !mem_en && !sc_boundary)); // R7
    AST_STROBE_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sc_boundary |-> (net_en && mem_en)); // R6
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (net_cnt == '0 && mem_cnt == '0)); // R8
endmodule

// File: tb/ratio_clk_enable_gen_tb.sv
`timescale 1ns/1ps
module ratio_clk_enable_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [7:0] net_div_in = '0, mem_div_in = '0, net_len_in = '0, mem_len_in = '0;
    logic       net_en, mem_en, sc_boundary, cfg_err;
    logic [7:0] net_cnt, mem_cnt;

    int checks = 0;
    int errors = 0;
    bit mon_on = 0;
    bit done = 0;

    typedef struct {
        bit ne; bit me; int nc; int mc; bit sb; bit er; bit first; bit unit;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ratio_clk_enable_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .net_div_in(net_div_in), .mem_div_in(mem_div_in),
        .net_len_in(net_len_in), .mem_len_in(mem_len_in),
        .net_en(net_en), .mem_en(mem_en), .net_cnt(net_cnt), .mem_cnt(mem_cnt),
        .sc_boundary(sc_boundary), .cfg_err(cfg_err)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per cycle and compare.
    always @(negedge clk) begin
        exp_t e;
        if (mon_on && q.size() != 0) begin
            e = q.pop_front();
            chk("R2 cfg_err", int'(cfg_err), int'(e.er));
            chk(e.er ? "R7 net_en" : (e.unit ? "R9 net_en" : "R3 net_en"), int'(net_en), int'(e.ne));
            chk(e.er ? "R7 mem_en" : "R4 mem_en", int'(mem_en), int'(e.me));
            chk(e.first ? "R8 net_cnt" : "R5 net_cnt", int'(net_cnt), e.nc);
            chk(e.first ? "R8 mem_cnt" : "R5 mem_cnt", int'(mem_cnt), e.mc);
            chk(e.er ? "R7 sc_boundary" : "R6 sc_boundary", int'(sc_boundary), int'(e.sb));
        end
    end

    // Driver: queue the expected sequence, load, then scramble the inputs.
    task automatic run_case(int m, int n, int nl, int ml, int cycles);
        bit ok;
        ok = (m != 0) && (n != 0) && (nl != 0) && (ml != 0) && (m * nl == n * ml);
        @(negedge clk);
        net_div_in = 8'(m); mem_div_in = 8'(n);
        net_len_in = 8'(nl); mem_len_in = 8'(ml);
        cfg_load = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            exp_t e;
            e.first = (i == 0);
            e.unit  = ok && (m == 1);
            e.er    = !ok;
            if (ok) begin
                e.ne = ((i % m) == m - 1);
                e.me = ((i % n) == n - 1);
                e.nc = (i / m) % nl;
                e.mc = (i / n) % ml;
                e.sb = (((i + 1) % (m * nl)) == 0);
            end else begin
                e.ne = 0; e.me = 0; e.nc = 0; e.mc = 0; e.sb = 0;
            end
            q.push_back(e);
        end
        @(posedge clk);
        #1;
        cfg_load = 1'b0;
        // R8: unloaded inputs must have no effect.
        net_div_in = 8'd7; mem_div_in = 8'd1; net_len_in = 8'd9; mem_len_in = 8'd0;
        mon_on = 1;
        wait (q.size() == 0);
        mon_on = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 net_en", int'(net_en), 0);
        chk("R1 mem_en", int'(mem_en), 0);
        chk("R1 net_cnt", int'(net_cnt), 0);
        chk("R1 mem_cnt", int'(mem_cnt), 0);
        chk("R1 sc_boundary", int'(sc_boundary), 0);
        chk("R1 cfg_err", int'(cfg_err), 1);

        run_case(2, 3, 6, 4, 40);   // 3:2 rate, 12-cycle service cycle
        run_case(2, 3, 6, 4, 17);   // reload mid-cycle restarts phase (R8)
        run_case(1, 4, 8, 2, 30);   // R9 divide by one
        run_case(3, 2, 4, 5, 20);   // R7 misaligned: 12 vs 10
        run_case(5, 3, 3, 5, 50);   // 15 = 15
        run_case(4, 2, 0, 3, 12);   // R2 zero length
        run_case(1, 1, 3, 3, 12);   // both every cycle, R9
        run_case(3, 6, 4, 2, 36);   // memory slower
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule